// File: doc/BRIEF.md
# SPI Master Frame Engine

This block is the serial core of an SPI master. Software programs a control word and a two-bit enable word. The engine then pulls words from an external transmit queue and shifts each one out on MOSI while it collects the same number of bits from MISO. Every received word goes to an external receive queue. A frame can be 8, 12, 16 or 32 bits long, sent with either the most or the least significant bit first. SCLK comes from a 16-bit half-period divider. Clock polarity and the drive edge are two separate settings.

A transfer is either one frame or a counted burst. In burst mode, a length word holds the number of frames minus one. A hardware-managed chip select is asserted for the whole transfer and falls back to a programmable idle level afterwards. Software can also take the chip-select pin over directly. When the last frame of a transfer is done, a one-cycle frame-end pulse is raised. If the transmit queue runs dry inside a burst, the engine shifts out a zero frame and reports an underflow pulse.

The controller has five named states:
- IDLE waits for a start.
- LOAD fetches the next transmit word.
- SHIFT toggles SCLK and moves the bits.
- NEXT hands over the received word and counts down the burst.
- DONE raises the frame-end pulse.

The transitions are:
- IDLE→LOAD when both enables are set and the transmit queue has data.
- LOAD→SHIFT always.
- SHIFT→NEXT on the last SCLK edge of a frame.
- NEXT→LOAD while frames remain, and NEXT→DONE otherwise.
- DONE→IDLE always.

Top module: `spi_frame_engine`

## Requirements
- R1: After reset SCLK, MOSI and the chip-select pin are 0, and busy, frame_end, tx_pop, rx_push and tx_underflow are all low.
- R2: Control bits [15:0] hold a divider D. Within a frame, every SCLK level between two edges lasts exactly D+1 clock cycles.
- R3: Control bits [27:26] choose the frame width (0 gives 8 bits, 1 gives 12, 2 gives 16, 3 gives 32). Each frame has exactly two SCLK edges per bit.
- R4: Control bit 22 set sends the frame's top bit first. Clear, bit 0 goes first. Received bits are placed by the same order, and unused upper bits of rx_data are 0.
- R5: Control bit 20 is the SCLK idle level. SCLK sits at that level whenever no transfer runs, including right after a transfer.
- R6: Control bit 23 set means MOSI changes on rising SCLK edges and MISO is sampled on falling edges. Clear, the edges swap. The first bit is on MOSI before the first sampling edge.
- R7: With control bit 19 clear, the chip-select pin equals control bit 21 when idle and its inverse during a transfer. With bit 19 set, the pin follows control bit 18. The pin never changes while a frame is shifting.
- R8: With control bit 31 set, a transfer runs L+1 frames, where L is the length word. With bit 31 clear, it runs exactly one frame whatever L holds.
- R9: A transfer starts only when enable bit 0 (receive) and enable bit 1 (transmit) are both set and tx_valid is high. Otherwise SCLK stays idle and nothing is popped.
- R10: frame_end is a single-cycle pulse, once per transfer, after the last frame, with SCLK already back at idle.
- R11: A frame that starts with tx_valid low shifts out all zeros and raises tx_underflow for one cycle instead of tx_pop.
- R12: Each frame pops at most one transmit word, in its first cycle, and pushes exactly one received word in its last cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 32 | Control word value |
| en_wr | input | 1 | Write strobe for the enable word |
| en_wdata | input | 2 | Bit 0 receive enable, bit 1 transmit enable |
| len_wr | input | 1 | Write strobe for the burst length word |
| len_wdata | input | LEN_W | Burst frame count minus one |
| tx_valid | input | 1 | Transmit queue holds a word |
| tx_data | input | 32 | Head word of the transmit queue |
| tx_pop | output | 1 | Consume the head transmit word |
| rx_push | output | 1 | rx_data carries a received frame |
| rx_data | output | 32 | Received frame, zero-extended |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_pin | output | 1 | Chip-select pin |
| frame_end | output | 1 | Transfer-complete pulse |
| tx_underflow | output | 1 | Zero frame sent because the queue was empty |
| busy | output | 1 | A transfer is in progress |

## Verification
Register writes take effect on the next edge. A start condition moves the engine to LOAD one cycle later, so tx_pop or tx_underflow is seen two cycles after the enable write. The first SCLK edge follows D+1 cycles later, and later edges are D+1 cycles apart. rx_push comes one cycle after the last edge of a frame, and frame_end one cycle after that. Level-type results (SCLK idle level, chip-select level, busy) are sampled on falling clock edges a few cycles after the write that sets them. Serial data and edge spacing are captured on every SCLK change by a slave model, and transfer results are compared only after frame_end has been seen, so no check depends on an exact start cycle.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    localparam int FE_DATA_W = 32;
    localparam int FE_DIV_W  = 16;
    localparam int FE_IDX_W  = $clog2(FE_DATA_W);
    localparam int FE_NB_W   = FE_IDX_W + 1;
    localparam int FE_EDGE_W = FE_IDX_W + 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_NEXT,
        ST_DONE
    } fe_state_t;

    typedef struct packed {
        logic                multi;
        logic [1:0]          fmt;
        logic                drv_rise;
        logic                msb_first;
        logic                cs_idle;
        logic                clk_idle;
        logic                cs_sw;
        logic                cs_val;
        logic [FE_DIV_W-1:0] div;
    } fe_cfg_t;

    function automatic logic [FE_NB_W-1:0] fmt_bits(input logic [1:0] f);
        case (f)
            2'd0:    return FE_NB_W'(8);
            2'd1:    return FE_NB_W'(12);
            2'd2:    return FE_NB_W'(16);
            default: return FE_NB_W'(32);
        endcase
    endfunction

endpackage

// File: rtl/spi_fe_regs.sv
module spi_fe_regs
    import spi_fe_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [31:0]      ctrl_wdata,
    input  logic             en_wr,
    input  logic [1:0]       en_wdata,
    input  logic             len_wr,
    input  logic [LEN_W-1:0] len_wdata,
    output fe_cfg_t          cfg,
    output logic [1:0]       en_q,
    output logic [LEN_W-1:0] len_q
);

    localparam int B_CSVAL  = 18;
    localparam int B_CSSW   = 19;
    localparam int B_CPOL   = 20;
    localparam int B_CSIDLE = 21;
    localparam int B_MSB    = 22;
    localparam int B_DRV    = 23;
    localparam int B_FMT    = 26;
    localparam int B_MULTI  = 31;

    fe_cfg_t decoded;
    logic    unused_ctrl;

    always_comb begin
        decoded.multi     = ctrl_wdata[B_MULTI];
        decoded.fmt       = ctrl_wdata[B_FMT+1:B_FMT];
        decoded.drv_rise  = ctrl_wdata[B_DRV];
        decoded.msb_first = ctrl_wdata[B_MSB];
        decoded.cs_idle   = ctrl_wdata[B_CSIDLE];
        decoded.clk_idle  = ctrl_wdata[B_CPOL];
        decoded.cs_sw     = ctrl_wdata[B_CSSW];
        decoded.cs_val    = ctrl_wdata[B_CSVAL];
        decoded.div       = ctrl_wdata[FE_DIV_W-1:0];
    end

    assign unused_ctrl = ^{ctrl_wdata[17:16], ctrl_wdata[25:24], ctrl_wdata[30:28]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg   <= '0;
            en_q  <= '0;
            len_q <= '0;
        end else begin
            if (ctrl_wr) cfg   <= decoded;
            if (en_wr)   en_q  <= en_wdata;
            if (len_wr)  len_q <= len_wdata;
        end
    end

endmodule

// File: rtl/spi_fe_baud.sv
module spi_fe_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == div) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/spi_fe_shift.sv
module spi_fe_shift
    import spi_fe_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [FE_DATA_W-1:0] load_word,
    input  logic [FE_NB_W-1:0]   nbits,
    input  logic                 msb_first,
    input  logic                 tick,
    input  logic                 is_drive,
    input  logic [FE_EDGE_W-1:0] edge_idx,
    input  logic                 miso,
    output logic                 mosi,
    output logic [FE_DATA_W-1:0] rx_word
);

    logic [FE_DATA_W-1:0] tx_q;
    logic [FE_EDGE_W-1:0] drv_i;
    logic [FE_EDGE_W-1:0] smp_i;

    // Serial position i maps to word bit (nbits-1-i) or i.
    function automatic logic [FE_IDX_W-1:0] bitpos(input logic [FE_EDGE_W-1:0] i,
                                                   input logic [FE_NB_W-1:0]   nb,
                                                   input logic                 msb);
        logic [FE_EDGE_W-1:0] t;
        t = msb ? (FE_EDGE_W'(nb) - FE_EDGE_W'(1) - i) : i;
        return t[FE_IDX_W-1:0];
    endfunction

    assign drv_i = (edge_idx + FE_EDGE_W'(1)) >> 1;
    assign smp_i = edge_idx >> 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q    <= '0;
            rx_word <= '0;
            mosi    <= 1'b0;
        end else if (load) begin
            tx_q    <= load_word;
            rx_word <= '0;
            mosi    <= load_word[bitpos('0, nbits, msb_first)];
        end else if (tick) begin
            if (is_drive) begin
                if (drv_i < FE_EDGE_W'(nbits)) begin
                    mosi <= tx_q[bitpos(drv_i, nbits, msb_first)];
                end
            end else begin
                rx_word[bitpos(smp_i, nbits, msb_first)] <= miso;
            end
        end
    end

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
    import spi_fe_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [31:0]      ctrl_wdata,
    input  logic             en_wr,
    input  logic [1:0]       en_wdata,
    input  logic             len_wr,
    input  logic [LEN_W-1:0] len_wdata,
    input  logic             tx_valid,
    input  logic [31:0]      tx_data,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [31:0]      rx_data,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    output logic             cs_pin,
    output logic             frame_end,
    output logic             tx_underflow,
    output logic             busy
);

    fe_state_t            state_q, state_d;
    fe_cfg_t              cfg, run_cfg;
    logic [1:0]           en_q;
    logic [LEN_W-1:0]     len_q, rem_q;
    logic [FE_EDGE_W-1:0] edge_q;
    logic [FE_NB_W-1:0]   nbits;
    logic                 tick, sclk_q, cs_q, cpha, is_drive, last_edge;
    logic [FE_DATA_W-1:0] load_word;
    logic                 unused_run;

    spi_fe_regs #(.LEN_W(LEN_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .en_wr      (en_wr),
        .en_wdata   (en_wdata),
        .len_wr     (len_wr),
        .len_wdata  (len_wdata),
        .cfg        (cfg),
        .en_q       (en_q),
        .len_q      (len_q)
    );

    spi_fe_baud #(.DIV_W(FE_DIV_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_SHIFT),
        .div   (run_cfg.div),
        .tick  (tick)
    );

    assign nbits     = fmt_bits(run_cfg.fmt);
    assign cpha      = run_cfg.clk_idle ^ run_cfg.drv_rise;
    assign is_drive  = edge_q[0] ^ cpha;
    assign last_edge = (edge_q == ({nbits, 1'b0} - FE_EDGE_W'(1)));
    assign load_word = tx_valid ? tx_data : '0;
    assign unused_run = ^{run_cfg.multi, run_cfg.cs_idle, run_cfg.cs_sw, run_cfg.cs_val};

    spi_fe_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (state_q == ST_LOAD),
        .load_word (load_word),
        .nbits     (nbits),
        .msb_first (run_cfg.msb_first),
        .tick      (tick),
        .is_drive  (is_drive),
        .edge_idx  (edge_q),
        .miso      (miso),
        .mosi      (mosi),
        .rx_word   (rx_data)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (en_q == 2'b11 && tx_valid) state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_SHIFT;
            ST_SHIFT: if (tick && last_edge) state_d = ST_NEXT;
            ST_NEXT:  state_d = (rem_q == '0) ? ST_DONE : ST_LOAD;
            ST_DONE:  state_d = ST_IDLE;
        endcase
    end

    // Registered outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cfg <= '0;
            rem_q   <= '0;
            edge_q  <= '0;
            sclk_q  <= 1'b0;
            cs_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    run_cfg <= cfg;
                    rem_q   <= cfg.multi ? len_q : '0;
                    edge_q  <= '0;
                    sclk_q  <= cfg.clk_idle;
                end
                ST_LOAD: edge_q <= '0;
                ST_SHIFT: begin
                    if (tick) begin
                        edge_q <= edge_q + FE_EDGE_W'(1);
                        sclk_q <= ~sclk_q;
                    end
                end
                ST_NEXT: if (rem_q != '0) rem_q <= rem_q - LEN_W'(1);
                default: ;
            endcase
            if (state_q != ST_SHIFT) begin
                cs_q <= cfg.cs_sw ? cfg.cs_val
                      : ((state_d != ST_IDLE) ? ~cfg.cs_idle : cfg.cs_idle);
            end
        end
    end

    assign sclk         = sclk_q;
    assign cs_pin       = cs_q;
    assign busy         = (state_q != ST_IDLE);
    assign tx_pop       = (state_q == ST_LOAD) && tx_valid;
    assign tx_underflow = (state_q == ST_LOAD) && !tx_valid;
    assign rx_push      = (state_q == ST_NEXT);
    assign frame_end    = (state_q == ST_DONE);

    a_r9_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && $past(state_q) == ST_IDLE) |-> $past(en_q == 2'b11 && tx_valid));

    a_r7_cs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && $past(state_q) == ST_SHIFT) |-> $stable(cs_pin));

    a_r6_mosi_on_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && $past(state_q) == ST_SHIFT && !$stable(mosi))
        |-> ($past(tick) && $past(is_drive)));

    a_r10_end_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end);

    a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $past(state_q) == ST_IDLE) |-> (sclk == $past(cfg.clk_idle)));

    a_r12_push_at_idle_clk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> (sclk == run_cfg.clk_idle));

endmodule

// File: tb/test_spi_frame_engine.sv
module test_spi_frame_engine;

    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 16;
    localparam int MAXF       = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctrl_wr = 1'b0, en_wr = 1'b0, len_wr = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic [1:0]  en_wdata = '0;
    logic [LEN_W-1:0] len_wdata = '0;
    logic tx_valid, tx_pop, rx_push, sclk, mosi, cs_pin, frame_end, tx_underflow, busy;
    logic miso = 1'b0;
    logic [31:0] tx_data, rx_data;

    spi_frame_engine #(.LEN_W(LEN_W)) i_spi_frame_engine (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .en_wr(en_wr), .en_wdata(en_wdata), .len_wr(len_wr), .len_wdata(len_wdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop), .rx_push(rx_push),
        .rx_data(rx_data), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_pin(cs_pin),
        .frame_end(frame_end), .tx_underflow(tx_underflow), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0, bad = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Transmit queue model
    logic [31:0] fifo [MAXF];
    int f_head = 0, f_cnt = 0;
    assign tx_valid = (f_head < f_cnt);
    assign tx_data  = tx_valid ? fifo[f_head % MAXF] : 32'h0;

    // Receive side and event counters
    logic [31:0] rx_got [MAXF];
    int rx_n = 0, fe_n = 0, fe_bad = 0, uf_n = 0;
    bit cur_cpol = 0, cur_drv = 0, cs_exp = 0;
    int cur_w = 8, cur_div = 0;

    always @(posedge clk) begin
        if (tx_pop) f_head <= f_head + 1;
        if (rx_push) begin
            rx_got[rx_n % MAXF] <= rx_data;
            rx_n <= rx_n + 1;
        end
        if (frame_end) begin
            fe_n <= fe_n + 1;
            if (sclk != cur_cpol) fe_bad <= fe_bad + 1;
        end
        if (tx_underflow) uf_n <= uf_n + 1;
    end

    // Slave model: samples MOSI and presents MISO per serial position
    logic [31:0] sl_stream [MAXF];
    logic [31:0] cap [MAXF];
    int nsamp = 0, nedge = 0, hb_bad = 0, cs_bad = 0;
    int sf, sk;
    time t_last = 0;

    always @(sclk) begin
        if (busy === 1'b1) begin
            nedge++;
            if (nedge > 1 && ((nedge - 1) % (2 * cur_w)) != 0) begin
                if (($time - t_last) != time'((cur_div + 1) * CLK_PERIOD)) hb_bad++;
            end
            t_last = $time;
            if (sclk != cur_drv) begin
                sf = nsamp / cur_w;
                sk = nsamp % cur_w;
                cap[sf % MAXF][sk] = mosi;
                if (cs_pin != cs_exp) cs_bad++;
                nsamp++;
                miso = sl_stream[(nsamp / cur_w) % MAXF][nsamp % cur_w];
            end
        end
    end

    function automatic int wbits(input logic [1:0] f);
        case (f)
            2'd0: return 8;
            2'd1: return 12;
            2'd2: return 16;
            default: return 32;
        endcase
    endfunction

    function automatic logic [31:0] to_stream(input logic [31:0] w, input int n, input bit msb);
        logic [31:0] s = '0;
        for (int k = 0; k < n; k++) s[k] = msb ? w[n-1-k] : w[k];
        return s;
    endfunction

    function automatic logic [31:0] from_stream(input logic [31:0] s, input int n, input bit msb);
        logic [31:0] r = '0;
        for (int k = 0; k < n; k++) r[msb ? n-1-k : k] = s[k];
        return r;
    endfunction

    function automatic logic [31:0] mk_ctrl(input logic [1:0] fmt, input bit msb, input bit cpol,
                                            input bit drv, input bit csidle, input bit cssw,
                                            input bit csval, input bit multi, input logic [15:0] div);
        logic [31:0] c = '0;
        c[15:0]  = div;
        c[18]    = csval;
        c[19]    = cssw;
        c[20]    = cpol;
        c[21]    = csidle;
        c[22]    = msb;
        c[23]    = drv;
        c[27:26] = fmt;
        c[31]    = multi;
        return c;
    endfunction

    task automatic wr_ctrl(input logic [31:0] v);
        @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_wr = 1'b0;
    endtask

    task automatic wr_en(input logic [1:0] v);
        @(negedge clk); en_wr = 1'b1; en_wdata = v;
        @(negedge clk); en_wr = 1'b0;
    endtask

    task automatic wr_len(input logic [LEN_W-1:0] v);
        @(negedge clk); len_wr = 1'b1; len_wdata = v;
        @(negedge clk); len_wr = 1'b0;
    endtask

    task automatic xfer(input logic [31:0] ctrl, input int len, input int nw);
        int nframes, w, guard, npop;
        logic [31:0] m, exp_tx;
        bit msb;
        nframes = ctrl[31] ? len + 1 : 1;
        w = wbits(ctrl[27:26]);
        msb = ctrl[22];
        m = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
        wr_en(2'b00);
        wr_ctrl(ctrl);
        wr_len(LEN_W'(len));
        cur_w = w; cur_div = int'(ctrl[15:0]);
        cur_cpol = ctrl[20]; cur_drv = ctrl[23];
        cs_exp = ctrl[19] ? ctrl[18] : ~ctrl[21];
        for (int i = 0; i < MAXF; i++) begin
            fifo[i] = $urandom;
            sl_stream[i] = $urandom;
            cap[i] = '0;
        end
        f_head = 0; f_cnt = nw;
        rx_n = 0; fe_n = 0; fe_bad = 0; uf_n = 0;
        nsamp = 0; nedge = 0; hb_bad = 0; cs_bad = 0;
        miso = sl_stream[0][0];
        repeat (3) @(negedge clk);
        wr_en(2'b11);
        guard = 0;
        while (fe_n == 0 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
        npop = (nw < nframes) ? nw : nframes;
        check(guard < 20000, "R10 transfer completes", guard, 0);
        check(fe_n == 1, "R10 one frame_end pulse", fe_n, 1);
        check(fe_bad == 0, "R10 sclk idle at frame_end", fe_bad, 0);
        check(rx_n == nframes, "R8 frame count", rx_n, nframes);
        check(nedge == 2 * w * nframes, "R3 sclk edge count", nedge, 2 * w * nframes);
        check(hb_bad == 0, "R2 half-period length", hb_bad, 0);
        check(f_head == npop, "R12 transmit pops", f_head, npop);
        check(uf_n == nframes - npop, "R11 underflow events", uf_n, nframes - npop);
        for (int f = 0; f < nframes; f++) begin
            exp_tx = (f < nw) ? (fifo[f] & m) : 32'h0;
            check((cap[f] & m) == to_stream(exp_tx, w, msb), "R4 mosi bit order", cap[f] & m,
                  to_stream(exp_tx, w, msb));
            check(rx_got[f] == from_stream(sl_stream[f], w, msb), "R6 sampled rx word", rx_got[f],
                  from_stream(sl_stream[f], w, msb));
        end
        check(sclk == cur_cpol, "R5 sclk idle after transfer", sclk, cur_cpol);
        check(cs_bad == 0, "R7 cs level during frames", cs_bad, 0);
        check(cs_pin == (ctrl[19] ? ctrl[18] : ctrl[21]), "R7 cs idle level", cs_pin,
              ctrl[19] ? ctrl[18] : ctrl[21]);
        check(busy == 1'b0, "R10 engine idle after end", busy, 0);
        wr_en(2'b00);
    endtask

    initial begin
        repeat (1900000 / CLK_PERIOD) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] c;
        int len, nf, nw;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        check(sclk == 0 && mosi == 0 && cs_pin == 0, "R1 pins after reset", {sclk, mosi, cs_pin}, 0);
        check(!busy && !frame_end && !tx_pop && !rx_push && !tx_underflow, "R1 strobes after reset",
              {busy, frame_end, tx_pop, rx_push, tx_underflow}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R9: start gating
        fifo[0] = 32'hA5; f_head = 0; f_cnt = 1;
        wr_en(2'b01);
        repeat (20) @(negedge clk);
        check(!busy && f_head == 0, "R9 no start with transmit disabled", busy, 0);
        wr_en(2'b10);
        repeat (20) @(negedge clk);
        check(!busy && f_head == 0, "R9 no start with receive disabled", busy, 0);
        f_cnt = 0;
        wr_en(2'b11);
        repeat (20) @(negedge clk);
        check(!busy && sclk == 0, "R9 no start with empty queue", busy, 0);
        wr_en(2'b00);

        // R5, R7: idle levels
        wr_ctrl(mk_ctrl(2'd0, 1, 1, 0, 1, 0, 0, 0, 16'd0));
        repeat (3) @(negedge clk);
        check(sclk == 1, "R5 sclk follows idle level", sclk, 1);
        check(cs_pin == 1, "R7 cs idle level from control", cs_pin, 1);
        wr_ctrl(mk_ctrl(2'd0, 1, 0, 0, 0, 1, 1, 0, 16'd0));
        repeat (3) @(negedge clk);
        check(cs_pin == 1, "R7 software cs high", cs_pin, 1);
        check(sclk == 0, "R5 sclk back to low idle", sclk, 0);
        wr_ctrl(mk_ctrl(2'd0, 1, 0, 0, 1, 1, 0, 0, 16'd0));
        repeat (3) @(negedge clk);
        check(cs_pin == 0, "R7 software cs low", cs_pin, 0);

        // Directed transfers over all four edge settings
        xfer(mk_ctrl(2'd0, 1, 0, 0, 1, 0, 0, 0, 16'd0), 0, 1);
        xfer(mk_ctrl(2'd1, 0, 1, 1, 0, 0, 0, 1, 16'd2), 2, 3);
        xfer(mk_ctrl(2'd2, 1, 0, 1, 1, 0, 0, 1, 16'd1), 3, 2);
        xfer(mk_ctrl(2'd3, 0, 1, 0, 0, 1, 1, 1, 16'd0), 1, 2);
        // R8: length ignored without burst mode
        xfer(mk_ctrl(2'd0, 0, 0, 1, 1, 0, 0, 0, 16'd1), 5, 1);

        // Random transfers
        for (int t = 0; t < 16; t++) begin
            c = mk_ctrl(2'($urandom % 4), 1'($urandom), 1'($urandom), 1'($urandom),
                        1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                        16'($urandom % 3));
            len = $urandom % 4;
            nf = c[31] ? len + 1 : 1;
            nw = 1 + ($urandom % nf);
            xfer(c, len, nw);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule